// File: doc/BRIEF.md
# Boolean bit processor unit

This unit carries out the single-bit operations of an 8-bit microcontroller core. It takes an already decoded operation code and an 8-bit bit address. It turns the address into a byte location and a bit position, and it works on the carry flag, on the addressed bit, or on both. The operations are: carry AND bit, carry AND inverted bit, carry OR bit, carry OR inverted bit, clear carry, set carry, clear bit and set bit.

Bytes are read and written through a single-port interface with a one-cycle read latency. That port covers internal RAM and the special-function register space, and it suits an inferred block RAM. The carry is bit 7 of the status word. The status word comes in on its own input, and any change goes back out as a complete byte with a write strobe. Every status-word update and every bit update is a read-modify-write: only the target bit changes.

Operations that touch only the carry finish in one cycle. Operations that need the addressed byte take three cycles: read, wait for the data, then write back or update the carry. While an operation is in progress the unit reports busy and ignores new requests.

Top module: `bitp_unit`

## Requirements
- R1: After a synchronous reset, busy, done, mem_rd_en, mem_wr_en and psw_we are all 0.
- R2: A bit address below 128 selects byte 0x20 plus (address >> 3), which covers bytes 0x20 to 0x2F. Bit position is address[2:0].
- R3: A bit address of 128 or more selects the byte whose address is the bit address with bits [2:0] cleared. Bit position is address[2:0].
- R4: The carry is psw_in[7]. Code 0 writes carry AND bit, and code 1 writes carry AND NOT bit. The result goes out on psw_wdata[7] with psw_we high and the other seven status bits unchanged. The byte is never written.
- R5: Code 2 writes carry OR bit, and code 3 writes carry OR NOT bit. The status-word rules are the same as in R4, and the byte is never written.
- R6: Code 4 clears the carry and code 5 sets it. In the cycle after the request is accepted, psw_we and done are high, no byte read is made, and the other status bits are unchanged.
- R7: Code 6 clears the addressed bit and code 7 sets it. The byte is written back with the other seven bits unchanged, and the status word is not written.
- R8: An accepted request with codes 0 to 3, 6 or 7 raises mem_rd_en with the byte address for one cycle, in the cycle after acceptance. Two cycles after that read strobe, done rises together with the write (mem_wr_en or psw_we).
- R9: A request presented while busy is high is ignored. Once the current operation ends, no further read or write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe, accepted when busy is low |
| op_code | input | 3 | Operation code, 0 to 7 as listed in R4 to R7 |
| bit_addr | input | 8 | Bit address operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 8 | Byte address toward RAM/register space |
| mem_rd_en | output | 1 | Byte read strobe; data returns one cycle later |
| mem_rdata | input | 8 | Byte read data |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data |
| psw_in | input | 8 | Current status word; bit 7 is the carry |
| psw_we | output | 1 | Status-word write strobe |
| psw_wdata | output | 8 | New status word |

## Verification
Each of the four logic codes is tried with all four pairings of carry and addressed-bit value. This separates AND from OR and plain from inverted operands, which a single pattern cannot do. The clear and set operations are aimed at the lowest and highest RAM bit addresses, at the first register-space address and at mid-range register bits, so that the two address regions and the bit-position decode are both exercised. The status word and the memory image hold mixed patterns, so a write that disturbs any neighbouring bit shows up. A request is also held high throughout a busy window to show that it starts nothing.

// File: rtl/bitp_pkg.sv
package bitp_pkg;

  typedef enum logic [2:0] {
    OP_ANL   = 3'd0,
    OP_ANL_N = 3'd1,
    OP_ORL   = 3'd2,
    OP_ORL_N = 3'd3,
    OP_CLR_C = 3'd4,
    OP_SET_C = 3'd5,
    OP_CLR_B = 3'd6,
    OP_SET_B = 3'd7
  } bitp_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_EXEC
  } bitp_state_e;

  function automatic logic op_uses_mem(input bitp_op_e op);
    return !(op == OP_CLR_C || op == OP_SET_C);
  endfunction

  function automatic logic op_writes_byte(input bitp_op_e op);
    return (op == OP_CLR_B || op == OP_SET_B);
  endfunction

endpackage

// File: rtl/bitp_addr_map.sv
module bitp_addr_map #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 32,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [SEL_W-1:0]  bit_pos
);

  always_comb begin
    bit_pos = bit_addr[SEL_W-1:0];
    if (bit_addr[ADDR_W-1]) begin
      // upper region: register space, byte aligned on the bit group
      byte_addr = {bit_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
    end else begin
      // lower region: packed bit-addressable RAM window
      byte_addr = ADDR_W'(RAM_BASE) + (bit_addr >> SEL_W);
    end
  end

endmodule

// File: rtl/bitp_alu.sv
module bitp_alu
  import bitp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  bitp_op_e          op,
  input  logic              cy_in,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [SEL_W-1:0]  bit_pos,
  output logic              cy_out,
  output logic [DATA_W-1:0] byte_out
);

  logic sel_bit;
  logic operand;
  logic new_bit;

  assign sel_bit = byte_in[bit_pos];
  assign operand = (op == OP_ANL_N || op == OP_ORL_N) ? ~sel_bit : sel_bit;
  assign new_bit = (op == OP_SET_B);

  always_comb begin
    case (op)
      OP_ANL, OP_ANL_N: cy_out = cy_in & operand;
      OP_ORL, OP_ORL_N: cy_out = cy_in | operand;
      OP_CLR_C:         cy_out = 1'b0;
      OP_SET_C:         cy_out = 1'b1;
      default:          cy_out = cy_in;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    assign byte_out[i] = (bit_pos == SEL_W'(i)) ? new_bit : byte_in[i];
  end

endmodule

// File: rtl/bitp_unit.sv
module bitp_unit
  import bitp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 32,
  parameter int CY_BIT   = 7,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] psw_in,
  output logic              psw_we,
  output logic [DATA_W-1:0] psw_wdata
);

  localparam logic [DATA_W-1:0] CY_MASK = DATA_W'(1) << CY_BIT;

  bitp_state_e       state;
  bitp_op_e          op_in;
  bitp_op_e          op_q;
  bitp_op_e          alu_op;
  logic [SEL_W-1:0]  pos_q;
  logic [ADDR_W-1:0] map_byte;
  logic [SEL_W-1:0]  map_pos;
  logic              alu_cy;
  logic [DATA_W-1:0] alu_byte;
  logic [DATA_W-1:0] psw_new;
  logic              accept;

  assign op_in  = bitp_op_e'(op_code);
  assign busy   = (state != S_IDLE);
  assign accept = op_valid && !busy;
  assign alu_op = (state == S_IDLE) ? op_in : op_q;

  bitp_addr_map #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RAM_BASE(RAM_BASE)
  ) u_map (
    .bit_addr (bit_addr),
    .byte_addr(map_byte),
    .bit_pos  (map_pos)
  );

  bitp_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .op      (alu_op),
    .cy_in   (psw_in[CY_BIT]),
    .byte_in (mem_rdata),
    .bit_pos (pos_q),
    .cy_out  (alu_cy),
    .byte_out(alu_byte)
  );

  always_comb begin
    psw_new         = psw_in;
    psw_new[CY_BIT] = alu_cy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_ANL;
      pos_q     <= '0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
      psw_we    <= 1'b0;
      psw_wdata <= '0;
    end else begin
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      psw_we    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (op_valid) begin
            if (op_uses_mem(op_in)) begin
              state     <= S_READ;
              op_q      <= op_in;
              pos_q     <= map_pos;
              mem_addr  <= map_byte;
              mem_rd_en <= 1'b1;
            end else begin
              psw_we    <= 1'b1;
              psw_wdata <= psw_new;
              done      <= 1'b1;
            end
          end
        end
        S_READ: state <= S_EXEC;
        S_EXEC: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (op_writes_byte(op_q)) begin
            mem_wr_en <= 1'b1;
            mem_wdata <= alu_byte;
          end else begin
            psw_we    <= 1'b1;
            psw_wdata <= psw_new;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!done && !mem_rd_en && !mem_wr_en && !psw_we && !busy));

  assert_map_ram_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && op_uses_mem(op_in) && !bit_addr[ADDR_W-1]) |=>
      (mem_rd_en && mem_addr == ADDR_W'(RAM_BASE) + ($past(bit_addr) >> SEL_W)));

  assert_map_sfr_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && op_uses_mem(op_in) && bit_addr[ADDR_W-1]) |=>
      (mem_rd_en && mem_addr[SEL_W-1:0] == '0 &&
       mem_addr[ADDR_W-1:SEL_W] == $past(bit_addr[ADDR_W-1:SEL_W])));

  assert_psw_keep_R4: assert property (@(posedge clk) disable iff (rst)
    psw_we |-> ((psw_wdata & ~CY_MASK) == ($past(psw_in) & ~CY_MASK)));

  assert_carry_only_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !op_uses_mem(op_in)) |=> (psw_we && done && !mem_rd_en && !mem_wr_en));

  assert_byte_keep_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

  assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && psw_we));

  assert_seq_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(mem_rd_en, 2));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && op_valid) |=> !mem_rd_en);

endmodule

// File: tb/tb_bitp_unit.sv
`timescale 1ns/1ps
module tb_bitp_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] bit_addr;
  logic       busy, done, mem_rd_en, mem_wr_en, psw_we;
  logic [7:0] mem_addr, mem_rdata, mem_wdata, psw_wdata;
  logic [7:0] psw;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_psw;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bitp_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .psw_in(psw), .psw_we(psw_we), .psw_wdata(psw_wdata)
  );

  // environment: byte memory with one-cycle read latency, status register
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (psw_we)    psw <= psw_wdata;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "busy idle", int'(busy), 0);
    chk(req, "done idle", int'(done), 0);
    chk(req, "rd idle", int'(mem_rd_en), 0);
    chk(req, "wr idle", int'(mem_wr_en), 0);
    chk(req, "psw_we idle", int'(psw_we), 0);
  endtask

  // issue one request and compare every cycle against the behavioural model
  task automatic run_op(input int op, input int a, input bit inject);
    int  b, pos, bitv, cy, ncy;
    bit  is_mem;
    string mreq, rreq;
    b      = (a < 128) ? 32 + (a / 8) : (a & 8'hF8);
    pos    = a % 8;
    is_mem = !(op == 4 || op == 5);
    mreq   = (a < 128) ? "R2" : "R3";
    rreq   = (op <= 1) ? "R4" : (op <= 3) ? "R5" : (op <= 5) ? "R6" : "R7";
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(op); bit_addr = 8'(a);
    @(negedge clk);
    op_valid = 1'b0;
    if (!is_mem) begin
      ncy = (op == 5) ? 1 : 0;
      chk("R6", "psw_we", int'(psw_we), 1);
      chk("R6", "done", int'(done), 1);
      chk("R6", "no read", int'(mem_rd_en), 0);
      chk("R6", "psw_wdata", int'(psw_wdata), int'((ref_psw & 8'h7F) | 8'(ncy << 7)));
      ref_psw = (ref_psw & 8'h7F) | 8'(ncy << 7);
      @(negedge clk);
      chk_quiet("R6");
      return;
    end
    chk("R8", "read strobe", int'(mem_rd_en), 1);
    chk(mreq, "byte addr", int'(mem_addr), b);
    chk("R8", "busy", int'(busy), 1);
    chk("R8", "done early", int'(done), 0);
    if (inject) begin
      op_valid = 1'b1; op_code = 3'd7; bit_addr = 8'h13;
    end
    @(negedge clk);
    chk("R8", "read once", int'(mem_rd_en), 0);
    chk("R8", "wait busy", int'(busy), 1);
    chk("R8", "wait done", int'(done), 0);
    chk("R8", "wait writes", int'(mem_wr_en | psw_we), 0);
    @(negedge clk);
    op_valid = 1'b0;
    bitv = (ref_mem[b] >> pos) & 1;
    cy   = ref_psw[7];
    chk("R8", "done", int'(done), 1);
    if (op <= 3) begin
      case (op)
        0: ncy = cy & bitv;
        1: ncy = cy & (1 - bitv);
        2: ncy = cy | bitv;
        default: ncy = cy | (1 - bitv);
      endcase
      chk(rreq, "psw_we", int'(psw_we), 1);
      chk(rreq, "no byte write", int'(mem_wr_en), 0);
      chk(rreq, "psw_wdata", int'(psw_wdata), int'((ref_psw & 8'h7F) | 8'(ncy << 7)));
      ref_psw = (ref_psw & 8'h7F) | 8'(ncy << 7);
    end else begin
      if (op == 7) ref_mem[b] = ref_mem[b] | 8'(1 << pos);
      else         ref_mem[b] = ref_mem[b] & ~8'(1 << pos);
      chk("R7", "byte write", int'(mem_wr_en), 1);
      chk("R7", "no psw write", int'(psw_we), 0);
      chk("R7", "write addr", int'(mem_addr), b);
      chk("R7", "write data", int'(mem_wdata), int'(ref_mem[b]));
    end
    @(negedge clk);
    chk_quiet(inject ? "R9" : "R8");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    psw = 8'h5A; ref_psw = 8'h5A;
    mem_rdata = '0;
    op_valid = 1'b0; op_code = '0; bit_addr = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_quiet("R1");

    // carry clear / set
    run_op(5, 0, 0);
    run_op(4, 0, 0);
    run_op(5, 0, 0);

    // bit writes at region edges and register-space addresses
    run_op(6, 8'h00, 0);
    run_op(7, 8'h7F, 0);
    run_op(6, 8'h7F, 0);
    run_op(7, 8'h80, 0);
    run_op(6, 8'hE5, 0);
    run_op(7, 8'hFF, 0);
    run_op(7, 8'h3A, 0);

    // every logic code against every carry/bit pairing
    for (int op = 0; op < 4; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int v = 0; v < 2; v++) begin
          run_op(c ? 5 : 4, 0, 0);
          run_op(v ? 7 : 6, (op % 2) ? 8'h9B : 8'h2C, 0);
          run_op(op, (op % 2) ? 8'h9B : 8'h2C, 0);
        end
      end
    end

    // request held during a busy window must not start anything
    run_op(7, 8'h51, 1);
    run_op(1, 8'hD3, 1);

    for (int i = 0; i < 256; i++)
      chk("R7", $sformatf("mem image %0d", i), int'(mem[i]), int'(ref_mem[i]));
    chk("R4", "psw image", int'(psw), int'(ref_psw));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule